// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a simple processor. It watches the request lines and records a rising edge on any of them as a pending request. It then tells the processor when to leave the work it is doing and which handler to enter. Each line has a fixed priority, and the line with the higher index ranks higher. A request whose priority is above the level in service preempts the running handler. A request at the same or a lower level waits.

The controller records every entered handler in an in-service mask. The highest set bit of that mask is the current level. When the processor signals that a handler has finished, only that bit is cleared. Any handler it had suspended then becomes current again, with no new grant. If a pending request ranks above whatever remains in service, it is granted on the following cycle. A status output stays high while nothing is in service, which means the interrupted main program runs.

Top module: `pic_nest_ctrl`

## Requirements
- R1: A request is recorded only on a 0-to-1 transition of its line. A line held high after its grant raises no second grant.
- R2: A grant is a one-cycle pulse on `grant_o`, with the line index on `vec_o`. For an idle controller it appears on the second rising clock edge after the line rises. In that same edge the index's bit of `in_service_o` is set and the request stops pending.
- R3: A pending request whose index is above the highest set bit of `in_service_o` is granted while the lower handler is still in service. It nests above that handler, and both bits stay set.
- R4: A pending request whose index is equal to or below the current level is not granted. It stays pending until the levels above it have completed.
- R5: When several pending requests are eligible in the same cycle, the highest index is granted first. The others follow one per completion, in descending order.
- R6: A one-cycle `done_i` clears only the highest set bit of `in_service_o`, on the next edge. A handler suspended below it becomes current again without a grant pulse.
- R7: No grant is issued on the edge that takes a `done_i`. On the next edge, the highest pending request above the remaining level is granted.
- R8: `main_o` is high exactly when `in_service_o` is zero. A `done_i` with nothing in service changes nothing.
- R9: After reset, `in_service_o` is zero, `grant_o` is low, `vec_o` is zero and `main_o` is high. Lines that are already high at reset do not count as requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Interrupt request lines; index 7 ranks highest with the defaults |
| done_i | input | 1 | One-cycle strobe: the current handler has finished |
| grant_o | output | 1 | One-cycle pulse: enter the handler named on `vec_o` |
| vec_o | output | VEC_W | Index of the granted line |
| in_service_o | output | NUM_LINES | Mask of entered and not yet finished handlers |
| main_o | output | 1 | High while no handler is in service |

## Verification
The embedded assertions check on every cycle that a granted vector is in service and is the top bit of the mask. They also check that no grant follows a done strobe, and that a done strobe on a non-empty mask removes exactly one bit. Other properties are visible only in the bench's scenarios, which step through every single line and every ordered pair of lines. These are the latency from a line edge to its grant, whether a request is held or preempts, the order in which simultaneous requests are served, and edge-only capture of a held line.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // Mask of positions strictly above the highest set bit of 'm';
   // all ones when 'm' is empty.
   function automatic logic [63:0] above_top(input logic [63:0] m, input int n);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < n) r[i] = ((m >> i) == 64'd0);
      end
      return r;
   endfunction
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o
);
   logic [NUM_LINES-1:0] req_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] rise;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign rise[g] = req_i[g] & ~req_q[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[g]  <= 1'b1;   // lines high at reset are not edges
            pend_q[g] <= 1'b0;
         end else begin
            req_q[g]  <= req_i[g];
            pend_q[g] <= (pend_q[g] & ~clr_i[g]) | rise[g];
         end
      end
   end

   assign pend_o = pend_q;

   // R1: a pending bit only appears after a rising edge or because it was already there
   p_pend_from_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q)) & ~($past(req_i) & ~$past(req_q))) == '0);
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int NUM_LINES = 8,
   localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [NUM_LINES-1:0] vec_i,
   output logic                 any_o,
   output logic [VEC_W-1:0]     idx_o
);
   assign any_o = |vec_i;

   if (NUM_LINES == 1) begin : g_single
      assign idx_o = '0;
   end else begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < NUM_LINES; i++) begin
            if (vec_i[i]) idx_o = VEC_W'(i);   // later (higher) index wins
         end
      end
   end
endmodule

// File: rtl/pic_service_stack.sv
module pic_service_stack #(
   parameter int NUM_LINES = 8,
   localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic [VEC_W-1:0]     push_idx_i,
   input  logic                 pop_i,
   output logic [NUM_LINES-1:0] isr_o,
   output logic [VEC_W-1:0]     level_o,
   output logic                 busy_o
);
   logic [NUM_LINES-1:0] isr_q;
   logic [NUM_LINES-1:0] isr_n;

   pic_prio_enc #(.NUM_LINES(NUM_LINES)) i_top (
      .vec_i (isr_q),
      .any_o (busy_o),
      .idx_o (level_o)
   );

   always_comb begin
      isr_n = isr_q;
      if (pop_i && busy_o) isr_n[level_o] = 1'b0;
      if (push_i)          isr_n[push_idx_i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_n;
   end

   assign isr_o = isr_q;

   // R6: a completion on a non-empty mask removes exactly one level
   p_pop_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && busy_o) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
   // R8: completion with nothing in service leaves the mask empty
   p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !busy_o) |=> (isr_q == '0));
endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl #(
   parameter int NUM_LINES = 8,
   localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic                 done_i,
   output logic                 grant_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic [NUM_LINES-1:0] in_service_o,
   output logic                 main_o
);
   import pic_pkg::*;

   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_cfg
      $error("pic_nest_ctrl: NUM_LINES must lie in 2..64");
   end

   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] clr;
   logic [NUM_LINES-1:0] isr;
   logic [NUM_LINES-1:0] eligible;
   logic [NUM_LINES-1:0] window;
   logic                 cand_any;
   logic [VEC_W-1:0]     cand_idx;
   logic                 take;
   logic [VEC_W-1:0]     level;
   logic                 busy;
   logic                 grant_q;
   logic [VEC_W-1:0]     vec_q;

   pic_edge_latch #(.NUM_LINES(NUM_LINES)) i_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign window   = NUM_LINES'(above_top(64'(isr), NUM_LINES));
   assign eligible = pend & window;

   pic_prio_enc #(.NUM_LINES(NUM_LINES)) i_pick (
      .vec_i (eligible),
      .any_o (cand_any),
      .idx_o (cand_idx)
   );

   assign take = cand_any & ~done_i;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr
      assign clr[g] = take && (cand_idx == VEC_W'(g));
   end

   pic_service_stack #(.NUM_LINES(NUM_LINES)) i_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (take),
      .push_idx_i (cand_idx),
      .pop_i      (done_i),
      .isr_o      (isr),
      .level_o    (level),
      .busy_o     (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         vec_q   <= '0;
      end else begin
         grant_q <= take;
         if (take) vec_q <= cand_idx;
      end
   end

   assign grant_o      = grant_q;
   assign vec_o        = vec_q;
   assign in_service_o = isr;
   assign main_o       = ~busy;

   // R2: the granted vector is in service while the grant pulses
   p_grant_in_service_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> isr[vec_q]);
   // R3: the granted vector is the top of the nesting
   p_grant_on_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> ((isr >> vec_q) == NUM_LINES'(1)));
   // R7: no grant follows the edge that took a completion
   p_no_grant_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !grant_q);
   // R2: grants are single-cycle pulses
   p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |=> (!grant_q || vec_q != $past(vec_q)));
endmodule

// File: tb/test_pic_nest_ctrl.sv
module test_pic_nest_ctrl;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         done = 1'b0;
   logic         grant;
   logic [2:0]   vec;
   logic [N-1:0] isr;
   logic         main_run;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   pic_nest_ctrl #(.NUM_LINES(N)) i_pic_nest_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .done_i       (done),
      .grant_o      (grant),
      .vec_o        (vec),
      .in_service_o (isr),
      .main_o       (main_run)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic expect_state(input string tag, input bit g, input int v,
                               input int m);
      chk(grant == g, tag, "grant", int'(grant), int'(g));
      if (g) chk(int'(vec) == v, tag, "vector", int'(vec), v);
      chk(int'(isr) == m, tag, "in_service", int'(isr), m);
      chk(main_run == (m == 0), tag, "main", int'(main_run), int'(m == 0));
   endtask

   task automatic finish_one();
      done = 1'b1;
      step();
      done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      // R9: reset state, with a line high during reset
      req = 8'h10;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      step();
      expect_state("R9", 1'b0, 0, 0);
      chk(vec == 3'd0, "R9", "vector", int'(vec), 0);
      req = '0;
      step();
      step();

      // R8: done with nothing in service is ignored
      finish_one();
      expect_state("R8", 1'b0, 0, 0);
      step();
      expect_state("R8", 1'b0, 0, 0);

      // single-line sweep: R2 latency, R1 edge-only, R6 completion
      for (int a = 0; a < N; a++) begin
         req[a] = 1'b1;
         step();
         expect_state("R2", 1'b0, 0, 0);
         step();
         expect_state("R2", 1'b1, a, 1 << a);
         step();
         expect_state("R2", 1'b0, 0, 1 << a);
         finish_one();
         expect_state("R6", 1'b0, 0, 0);
         step();
         expect_state("R1", 1'b0, 0, 0);   // line still high: no new grant
         step();
         expect_state("R1", 1'b0, 0, 0);
         req[a] = 1'b0;
         step();
      end

      // ordered-pair sweep: R3 preempt, R4 hold, R6 resume, R7 deferred grant
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a == b) continue;
            req[a] = 1'b1;
            step();
            step();
            expect_state("R2", 1'b1, a, 1 << a);
            req[a] = 1'b0;
            req[b] = 1'b1;
            step();
            step();
            if (b > a) begin
               expect_state("R3", 1'b1, b, (1 << a) | (1 << b));
               req[b] = 1'b0;
               finish_one();
               expect_state("R6", 1'b0, 0, 1 << a);
               finish_one();
               expect_state("R6", 1'b0, 0, 0);
            end else begin
               expect_state("R4", 1'b0, 0, 1 << a);
               req[b] = 1'b0;
               step();
               expect_state("R4", 1'b0, 0, 1 << a);
               finish_one();
               expect_state("R7", 1'b0, 0, 0);
               step();
               expect_state("R7", 1'b1, b, 1 << b);
               finish_one();
               expect_state("R6", 1'b0, 0, 0);
            end
            step();
         end
      end

      // R5: simultaneous requests, highest first, then descending
      req = 8'b1010_0100;
      step();
      step();
      expect_state("R5", 1'b1, 7, 8'h80);
      req = '0;
      step();
      expect_state("R5", 1'b0, 0, 8'h80);
      finish_one();
      expect_state("R5", 1'b0, 0, 0);
      step();
      expect_state("R5", 1'b1, 5, 8'h20);
      finish_one();
      step();
      expect_state("R5", 1'b1, 2, 8'h04);
      finish_one();
      expect_state("R5", 1'b0, 0, 0);
      step();

      // R4: equal level re-raised while in service is held
      req[3] = 1'b1;
      step();
      step();
      expect_state("R4", 1'b1, 3, 8'h08);
      req[3] = 1'b0;
      step();
      req[3] = 1'b1;
      step();
      step();
      expect_state("R4", 1'b0, 0, 8'h08);
      req[3] = 1'b0;
      finish_one();
      expect_state("R7", 1'b0, 0, 0);
      step();
      expect_state("R7", 1'b1, 3, 8'h08);
      finish_one();
      expect_state("R8", 1'b0, 0, 0);

      // R3/R6: three-deep nesting unwinds in order
      req[1] = 1'b1;
      step(); step();
      req[4] = 1'b1;
      step(); step();
      req[6] = 1'b1;
      step(); step();
      expect_state("R3", 1'b1, 6, 8'h52);
      req = '0;
      finish_one();
      expect_state("R6", 1'b0, 0, 8'h12);
      finish_one();
      expect_state("R6", 1'b0, 0, 8'h02);
      finish_one();
      expect_state("R8", 1'b0, 0, 0);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule